// File: doc/BRIEF.md
# ChaCha Block Keystream XOR Core

The core turns one 512-bit ChaCha input state into keystream and XORs it into one 64-byte data block. The state is sixteen 32-bit words held as four rows of four words. The core runs the ChaCha permutation iteratively, one full double round per clock. It then adds the original state back word by word and XORs the sum into the data block. A caller presents state, data and an even round count together with a start request. It takes the result when the one-cycle done flag is high.

Inside, the state stays as four row vectors. A column step applies the same quarter-round arithmetic to all four lanes of the rows at once. The diagonal step reuses that arithmetic after rows 1, 2 and 3 have been rotated left by one, two and three word positions. The rotations are undone at the end of each double round.

A round count of zero, or any odd count, is refused. The refusal is reported at once and nothing is computed.

Top module: `chacha_xor_core`

## Requirements
- R1: Word i (i = 0..15) of `state_i`, `data_i` and `data_o` sits at bits [32*i+31 : 32*i]. Row r holds words 4r..4r+3. Each data word is read as little-endian bytes, so byte j of the block is bits [8j+7 : 8j].
- R2: A start accepted with a zero or odd `rounds_i` raises `done_o` and `illegal_o` together for exactly the next cycle. `ready_o` stays high and `data_o` keeps its previous value.
- R3: A start accepted with an even, non-zero `rounds_i` drops `ready_o` from the next cycle on. `done_o` then rises for one cycle, exactly rounds_i/2 + 1 clock edges after the accepting edge. `ready_o` is high again in that same cycle, and `done_o` is never high while `ready_o` is low.
- R4: On a legal done, `data_o` word i equals `data_i` word i XOR (permuted word i + `state_i` word i), with the addition taken modulo 2^32. Every quarter-round step runs on whole rows: a+=b, d^=a, d rotl 16; c+=d, b^=c, b rotl 12; a+=b, d^=a, d rotl 8; c+=d, b^=c, b rotl 7. With a 20-round count and a zero data block, the standard test state (key bytes 00..1f, block counter 1, nonce 000000090000004a00000000) gives word 0 = e4e7f110 and word 15 = 4e3c50a2.
- R5: Each double round is a column step, then a diagonal step. The diagonal step sees rows 1, 2 and 3 rotated left by one, two and three words. For counts of 8 and 12 the output matches a reference that uses the usual diagonal index sets.
- R6: Requests on `start_i` and changes on `state_i`, `data_i` and `rounds_i` while `ready_o` is low have no effect on the result or on its timing.
- R7: `data_o` changes only in a cycle where `done_o` is high.
- R8: After reset `ready_o` is 1, `done_o` and `illegal_o` are 0 and `data_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request; accepted at a rising edge while ready_o is high |
| ready_o | output | 1 | Core is idle and will accept a request |
| rounds_i | input | RCNT_W (6) | Round count; must be even and non-zero |
| state_i | input | 512 | Input state, word i at bits 32i+31:32i |
| data_i | input | 512 | Data block, same word layout |
| done_o | output | 1 | One-cycle completion flag |
| illegal_o | output | 1 | High with done_o when the round count was refused |
| data_o | output | 512 | Output block, held between completions |

## Verification
The bound checker watches the handshake on every cycle. It checks that no completion appears while the core is busy and that the core stays busy until a counter loaded with half the round count has drained. It also checks that a refused count answers on the very next cycle with ready still high, and that the output block moves only with a completion. Whether the arithmetic is right, including the row rotations, the add-back of the original state and the data XOR, can only be shown by the bench's scenarios. These are the standard 20-round vector, random blocks at 8 and 12 rounds, and a run in which inputs are disturbed while the core is busy. Each is compared against a behavioural reference that uses diagonal index sets instead of row rotation.

// File: rtl/chx_pkg.sv
package chx_pkg;
   localparam int unsigned WORD_W   = 32;
   localparam int unsigned ROW_LEN  = 4;
   localparam int unsigned NUM_ROWS = 4;
   localparam int unsigned IDX_W    = $clog2(ROW_LEN);
   localparam int unsigned ROT_D1   = 16;
   localparam int unsigned ROT_B1   = 12;
   localparam int unsigned ROT_D2   = 8;
   localparam int unsigned ROT_B2   = 7;

   typedef logic [WORD_W-1:0]       word_t;
   typedef word_t [ROW_LEN-1:0]     row_t;
   typedef row_t  [NUM_ROWS-1:0]    blk_t;

   typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FIN} phase_e;

   function automatic word_t rotl(input word_t x, input int unsigned n);
      return (x << n) | (x >> (WORD_W - n));
   endfunction

   // word k of the result is word (k+n) mod ROW_LEN of the input
   function automatic row_t row_shift(input row_t r, input int unsigned n);
      row_t o;
      for (int unsigned k = 0; k < ROW_LEN; k++)
         o[k] = r[IDX_W'((k + n) % ROW_LEN)];
      return o;
   endfunction
endpackage

// File: rtl/chx_quarter.sv
module chx_quarter
   import chx_pkg::*;
(
   input  row_t a_i,
   input  row_t b_i,
   input  row_t c_i,
   input  row_t d_i,
   output row_t a_o,
   output row_t b_o,
   output row_t c_o,
   output row_t d_o
);
   // one quarter-round step applied lane-wise to whole rows (R4)
   for (genvar k = 0; k < ROW_LEN; k++) begin : g_lane
      word_t a1, b1, c1, d1, a2, b2, c2, d2;
      assign a1 = a_i[k] + b_i[k];
      assign d1 = rotl(d_i[k] ^ a1, ROT_D1);
      assign c1 = c_i[k] + d1;
      assign b1 = rotl(b_i[k] ^ c1, ROT_B1);
      assign a2 = a1 + b1;
      assign d2 = rotl(d1 ^ a2, ROT_D2);
      assign c2 = c1 + d2;
      assign b2 = rotl(b1 ^ c2, ROT_B2);
      assign a_o[k] = a2;
      assign b_o[k] = b2;
      assign c_o[k] = c2;
      assign d_o[k] = d2;
   end
endmodule

// File: rtl/chx_dround.sv
module chx_dround
   import chx_pkg::*;
(
   input  blk_t blk_i,
   output blk_t blk_o
);
   blk_t col_o, diag_i, diag_o;

   chx_quarter u_col (
      .a_i(blk_i[0]), .b_i(blk_i[1]), .c_i(blk_i[2]), .d_i(blk_i[3]),
      .a_o(col_o[0]), .b_o(col_o[1]), .c_o(col_o[2]), .d_o(col_o[3])
   );

   // row r rotated left by r words lines diagonals up as columns (R5)
   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_skew
      assign diag_i[r] = row_shift(col_o[r], r);
      assign blk_o[r]  = row_shift(diag_o[r], (ROW_LEN - r) % ROW_LEN);
   end

   chx_quarter u_diag (
      .a_i(diag_i[0]), .b_i(diag_i[1]), .c_i(diag_i[2]), .d_i(diag_i[3]),
      .a_o(diag_o[0]), .b_o(diag_o[1]), .c_o(diag_o[2]), .d_o(diag_o[3])
   );
endmodule

// File: rtl/chx_mix.sv
module chx_mix
   import chx_pkg::*;
(
   input  blk_t work_i,
   input  blk_t orig_i,
   input  blk_t data_i,
   output blk_t out_o
);
   // feed-forward add of the original state, then XOR with data (R4)
   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      for (genvar k = 0; k < ROW_LEN; k++) begin : g_word
         assign out_o[r][k] = data_i[r][k] ^ (work_i[r][k] + orig_i[r][k]);
      end
   end
endmodule

// File: rtl/chacha_xor_core.sv
module chacha_xor_core
   import chx_pkg::*;
#(
   parameter int unsigned RCNT_W = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start_i,
   output logic                            ready_o,
   input  logic [RCNT_W-1:0]               rounds_i,
   input  logic [WORD_W*ROW_LEN*NUM_ROWS-1:0] state_i,
   input  logic [WORD_W*ROW_LEN*NUM_ROWS-1:0] data_i,
   output logic                            done_o,
   output logic                            illegal_o,
   output logic [WORD_W*ROW_LEN*NUM_ROWS-1:0] data_o
);
   localparam int unsigned DR_W = RCNT_W - 1;

   if (RCNT_W < 2) begin : g_bad_rcnt
      $error("chacha_xor_core: RCNT_W must be at least 2");
   end
   if (WORD_W != 32) begin : g_bad_word
      $error("chacha_xor_core: rotation amounts assume 32-bit words");
   end

   phase_e            phase;
   logic [DR_W-1:0]   dr_left;
   blk_t              work, orig, dat;
   blk_t              dr_out, mix_out;
   logic              legal;

   assign legal   = (rounds_i != '0) && !rounds_i[0];
   assign ready_o = (phase == PH_IDLE);

   chx_dround u_dround (
      .blk_i(work),
      .blk_o(dr_out)
   );

   chx_mix u_mix (
      .work_i(work),
      .orig_i(orig),
      .data_i(dat),
      .out_o (mix_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         dr_left   <= '0;
         work      <= '0;
         orig      <= '0;
         dat       <= '0;
         done_o    <= 1'b0;
         illegal_o <= 1'b0;
         data_o    <= '0;
      end else begin
         done_o    <= 1'b0;
         illegal_o <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               if (start_i) begin
                  if (legal) begin
                     work    <= blk_t'(state_i);
                     orig    <= blk_t'(state_i);
                     dat     <= blk_t'(data_i);
                     dr_left <= rounds_i[RCNT_W-1:1];
                     phase   <= PH_RUN;
                  end else begin
                     done_o    <= 1'b1;
                     illegal_o <= 1'b1;
                  end
               end
            end
            PH_RUN: begin
               work    <= dr_out;
               dr_left <= dr_left - 1'b1;
               if (dr_left == DR_W'(1)) phase <= PH_FIN;
            end
            PH_FIN: begin
               data_o <= mix_out;
               done_o <= 1'b1;
               phase  <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/chx_checker.sv
module chx_checker #(
   parameter int unsigned RCNT_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              ready_o,
   input logic [RCNT_W-1:0] rounds_i,
   input logic              done_o,
   input logic              illegal_o,
   input logic [511:0]      data_o
);
   logic              ok_cnt;
   logic              accept;
   logic [RCNT_W-1:0] lat_left;

   assign ok_cnt = (rounds_i != '0) && !rounds_i[0];
   assign accept = start_i && ready_o;

   always_ff @(posedge clk) begin
      if (!rst_n)                  lat_left <= '0;
      else if (accept && ok_cnt)   lat_left <= rounds_i >> 1;
      else if (lat_left != '0)     lat_left <= lat_left - 1'b1;
   end

   AST_LEGAL_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      accept && ok_cnt |=> !ready_o && !done_o); // R3
   AST_BUSY_WHILE_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
      lat_left != '0 |-> !ready_o); // R3
   AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_o |-> !done_o); // R3
   AST_DONE_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> lat_left == '0); // R3
   AST_ILLEGAL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !ok_cnt |=> done_o && illegal_o && ready_o); // R2
   AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> done_o); // R2
   AST_ILLEGAL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> $stable(data_o)); // R2
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(data_o)); // R7
endmodule

bind chacha_xor_core chx_checker #(.RCNT_W(RCNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .ready_o  (ready_o),
   .rounds_i (rounds_i),
   .done_o   (done_o),
   .illegal_o(illegal_o),
   .data_o   (data_o)
);

// File: tb/chacha_xor_core_tb.sv
module chacha_xor_core_tb;
   localparam int RW = 6;
   localparam int WD_LIMIT = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [RW-1:0] rounds_i = '0;
   logic [511:0]  state_i = '0;
   logic [511:0]  data_i = '0;
   logic          ready_o, done_o, illegal_o;
   logic [511:0]  data_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   chacha_xor_core #(.RCNT_W(RW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_o(ready_o),
      .rounds_i(rounds_i), .state_i(state_i), .data_i(data_i),
      .done_o(done_o), .illegal_o(illegal_o), .data_o(data_o)
   );

   function automatic logic [31:0] rl(input logic [31:0] x, input int n);
      return (x << n) | (x >> (32 - n));
   endfunction

   // behavioural reference using diagonal index sets (R4, R5)
   function automatic logic [511:0] ref_block(input logic [511:0] st,
                                              input logic [511:0] dt,
                                              input int rounds);
      logic [31:0] x[16];
      logic [511:0] o;
      int ia, ib, ic, id;
      for (int i = 0; i < 16; i++) x[i] = st[32*i +: 32];
      for (int r = 0; r < rounds / 2; r++) begin
         for (int q = 0; q < 8; q++) begin
            ia = q % 4;
            if (q < 4) begin
               ib = 4 + ia; ic = 8 + ia; id = 12 + ia;
            end else begin
               ib = 4 + (ia + 1) % 4; ic = 8 + (ia + 2) % 4; id = 12 + (ia + 3) % 4;
            end
            x[ia] = x[ia] + x[ib]; x[id] = rl(x[id] ^ x[ia], 16);
            x[ic] = x[ic] + x[id]; x[ib] = rl(x[ib] ^ x[ic], 12);
            x[ia] = x[ia] + x[ib]; x[id] = rl(x[id] ^ x[ia], 8);
            x[ic] = x[ic] + x[id]; x[ib] = rl(x[ib] ^ x[ic], 7);
         end
      end
      for (int i = 0; i < 16; i++)
         o[32*i +: 32] = dt[32*i +: 32] ^ (x[i] + st[32*i +: 32]);
      return o;
   endfunction

   // cycle-by-cycle model
   logic         m_ready = 1'b1, m_done = 1'b0, m_ill = 1'b0;
   logic [511:0] m_data = '0, m_res = '0;
   int           m_left = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ready = 1'b1; m_done = 1'b0; m_ill = 1'b0; m_data = '0; m_left = 0;
      end else begin
         m_done = 1'b0; m_ill = 1'b0;
         if (m_ready && start_i) begin
            if (rounds_i != 0 && rounds_i[0] == 1'b0) begin
               m_ready = 1'b0;
               m_left  = int'(rounds_i) / 2;
               m_res   = ref_block(state_i, data_i, int'(rounds_i));
            end else begin
               m_done = 1'b1; m_ill = 1'b1;
            end
         end else if (!m_ready) begin
            if (m_left > 0) m_left--;
            else begin
               m_done = 1'b1; m_ready = 1'b1; m_data = m_res;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [511:0] act,
                      input logic [511:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(ready_o === m_ready, "R3 ready_o", 512'(ready_o), 512'(m_ready));
         chk(done_o === m_done, "R3 done_o", 512'(done_o), 512'(m_done));
         chk(illegal_o === m_ill, "R2 illegal_o", 512'(illegal_o), 512'(m_ill));
         chk(data_o === m_data, "R4 R7 data_o", data_o, m_data);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         errors++;
         $display("FAIL R3 watchdog: actual=no completion expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [511:0] rnd512();
      logic [511:0] v;
      for (int i = 0; i < 16; i++) v[32*i +: 32] = $urandom;
      return v;
   endfunction

   task automatic issue(input logic [511:0] st, input logic [511:0] dt, input int rn);
      @(negedge clk);
      state_i = st; data_i = dt; rounds_i = RW'(rn); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done();
      while (!done_o) @(negedge clk);
   endtask

   logic [511:0] vec_st;
   logic [511:0] hold;

   initial begin
      vec_st = {32'h00000000, 32'h4a000000, 32'h09000000, 32'h00000001,
                32'h1f1e1d1c, 32'h1b1a1918, 32'h17161514, 32'h13121110,
                32'h0f0e0d0c, 32'h0b0a0908, 32'h07060504, 32'h03020100,
                32'h6b206574, 32'h79622d32, 32'h3320646e, 32'h61707865};
      repeat (4) @(negedge clk);
      // R8: reset values
      chk(ready_o === 1'b1, "R8 ready_o", 512'(ready_o), 512'(1));
      chk(done_o === 1'b0, "R8 done_o", 512'(done_o), 512'(0));
      chk(illegal_o === 1'b0, "R8 illegal_o", 512'(illegal_o), 512'(0));
      chk(data_o === '0, "R8 data_o", data_o, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4, R1: standard 20-round vector, zero data
      issue(vec_st, '0, 20);
      wait_done();
      chk(data_o[31:0] === 32'he4e7f110, "R4 R1 word0", 512'(data_o[31:0]), 512'(32'he4e7f110));
      chk(data_o[511:480] === 32'h4e3c50a2, "R4 R1 word15", 512'(data_o[511:480]), 512'(32'h4e3c50a2));
      chk(data_o === ref_block(vec_st, '0, 20), "R4 full block", data_o, ref_block(vec_st, '0, 20));

      // R4: same state with nonzero data
      hold = rnd512();
      issue(vec_st, hold, 20);
      wait_done();
      chk(data_o === ref_block(vec_st, hold, 20), "R4 data xor", data_o, ref_block(vec_st, hold, 20));

      // R5: 8 and 12 rounds on random blocks
      for (int t = 0; t < 3; t++) begin
         logic [511:0] s, d;
         s = rnd512(); d = rnd512();
         issue(s, d, 8);
         wait_done();
         chk(data_o === ref_block(s, d, 8), "R5 8 rounds", data_o, ref_block(s, d, 8));
         s = rnd512(); d = rnd512();
         issue(s, d, 12);
         wait_done();
         chk(data_o === ref_block(s, d, 12), "R5 12 rounds", data_o, ref_block(s, d, 12));
      end

      // R2: zero and odd counts refused, data_o unchanged
      hold = data_o;
      issue(rnd512(), rnd512(), 0);
      chk(done_o === 1'b1 && illegal_o === 1'b1, "R2 zero count", 512'({done_o, illegal_o}), 512'(2'b11));
      chk(data_o === hold, "R2 zero keeps data", data_o, hold);
      issue(rnd512(), rnd512(), 7);
      chk(done_o === 1'b1 && illegal_o === 1'b1, "R2 odd count", 512'({done_o, illegal_o}), 512'(2'b11));
      chk(ready_o === 1'b1, "R2 ready stays", 512'(ready_o), 512'(1));
      chk(data_o === hold, "R2 odd keeps data", data_o, hold);

      // R6: disturb inputs and hold start while busy
      begin
         logic [511:0] s, d;
         s = rnd512(); d = rnd512();
         @(negedge clk);
         state_i = s; data_i = d; rounds_i = RW'(12); start_i = 1'b1;
         @(negedge clk);
         state_i = rnd512(); data_i = rnd512(); rounds_i = RW'(8);
         repeat (3) @(negedge clk);
         start_i = 1'b0;
         wait_done();
         chk(data_o === ref_block(s, d, 12), "R6 busy inputs ignored", data_o, ref_block(s, d, 12));
      end

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule